// File: doc/BRIEF.md
# Byte-Aligned Serial ADC Read Controller

This block is the host side of a read from a three-wire serial analog-to-digital converter that delivers a 12-bit result. It drives an active-low select line and a serial clock toward the converter and takes in the converter's data line. A one-cycle `start` pulse begins a read. When the read ends, the block shows the result as a high byte and a low byte and raises `done` for one cycle.

After its most-significant-bit-first word, the converter repeats the same bits least-significant first. The controller does not reorder any bits. Before the select line falls, it parks the clock low. After the select line falls, it adds one extra clock pulse. Together these two steps shift the trailing stream so that three 8-bit, LSB-first byte transfers align with the result's nibble and byte boundaries. The upper nibble of the second byte holds result bits 3..0, and the third byte holds result bits 11..4. The first byte is discarded.

The sequencer states, in order, are S_IDLE, S_PRE_LOW, S_SELECT, S_XTRA_HI, S_XTRA_LO, S_ARM, then alternating S_BIT_LO and S_BIT_HI, then S_RELEASE.

The transitions are:
- S_IDLE goes to S_PRE_LOW on `start`.
- Each timed state moves to the next state when a half-period ends.
- S_BIT_HI goes back to S_BIT_LO until three bytes have been received, and then goes to S_RELEASE.
- S_RELEASE goes to S_IDLE after one cycle.

The serial clock period is CLK_DIV system clocks, so each half-period lasts CLK_DIV/2 system clocks. CLK_DIV must be even and at least 4.

Top module: `adc_aligned_reader`

## Requirements
- R1: After reset, `adc_sel_n`=1, `adc_clk`=1, `done`=0, and `res_hi`=`res_lo`=0.
- R2: An accepted `start` first drives `adc_clk` low for one half-period while `adc_sel_n` stays high. `adc_sel_n` then falls while `adc_clk` is low, and both stay in that state for one more half-period.
- R3: With `adc_sel_n` low, one extra pulse follows: `adc_clk` is high for a half-period, then low for a half-period, then high for a half-period. Only after this does bit reception start.
- R4: Reception is 24 bit periods. In each, `adc_clk` is low for CLK_DIV/2 cycles and then high for CLK_DIV/2 cycles, with `adc_sel_n` low throughout.
- R5: `adc_din` is sampled when `adc_clk` rises. Every 8 samples form one byte, with the first sample in bit 0.
- R6: `res_lo` equals the second byte ANDed with 8'hF0. For a converter result V, this gives {V[3:0],4'b0000}.
- R7: `res_hi` equals the third byte unchanged, which is V[11:4].
- R8: `adc_sel_n` and `adc_clk` return high one cycle after the last high half-period. `done` is high for exactly one cycle, on the cycle after `adc_sel_n` rises.
- R9: A `start` seen while a read is in progress, including during S_RELEASE, is ignored. A `start` present during the `done` cycle begins a new read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request one read |
| adc_din | input | 1 | Serial data from the converter |
| adc_sel_n | output | 1 | Converter select, active low |
| adc_clk | output | 1 | Serial clock to the converter, idles high |
| res_hi | output | 8 | Result bits 11..4 |
| res_lo | output | 8 | Result bits 3..0 in the upper nibble, zeros below |
| done | output | 1 | One-cycle pulse marking a finished read |

## Verification
The bench runs a behavioural converter that counts falling clock edges after select falls and emits a null bit, the word MSB first, and then the word LSB first. It compares the select, clock and done waveform against a reference timeline on every cycle.

The corner cases the bench targets, and what each error would show:
- Stimulus: all-zero, all-one and edge-bit result values. Error shown: without the parked-low clock or the extra pulse, the bytes come out shifted by one bit and bit 11 is lost.
- Stimulus: a `start` pulse in mid-read. Error shown: a design that restarts on it breaks the timeline.
- Stimulus: a `start` held through the `done` cycle. Error shown: a design that refuses back-to-back reads misses the second read.
- Stimulus: checking `res_lo`. Error shown: a missing 0xF0 mask leaves stale bits in the low nibble.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
    localparam int BYTE_W   = 8;
    localparam int NUM_XFER = 3;
    localparam logic [BYTE_W-1:0] LO_MASK = 8'hF0;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PRE_LOW,
        S_SELECT,
        S_XTRA_HI,
        S_XTRA_LO,
        S_ARM,
        S_BIT_LO,
        S_BIT_HI,
        S_RELEASE
    } rd_state_e;
endpackage

// File: rtl/adc_rd_halfper.sv
module adc_rd_halfper #(
    parameter int HALF = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = !hold && (cnt_q == LAST);

    // R4: a half-period is never a single cycle
    assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] byte_q,
    output logic         byte_done
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q     <= '0;
            byte_q    <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= shift_en && (cnt_q == LAST);
            if (shift_en) begin
                byte_q <= {bit_in, byte_q[W-1:1]};
                cnt_q  <= cnt_q + 1'b1;
            end
        end
    end

    // R5: a completed byte always follows a sampling step
    assert_byte_after_shift_R5: assert property (@(posedge clk) disable iff (rst)
        byte_done |-> $past(shift_en));
endmodule

// File: rtl/adc_aligned_reader.sv
module adc_aligned_reader
    import adc_rd_pkg::*;
#(
    parameter int CLK_DIV = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              adc_din,
    output logic              adc_sel_n,
    output logic              adc_clk,
    output logic [BYTE_W-1:0] res_hi,
    output logic [BYTE_W-1:0] res_lo,
    output logic              done
);
    localparam int HALF = CLK_DIV / 2;
    localparam int XW   = $clog2(NUM_XFER + 1);
    localparam logic [XW-1:0] XFER_LO  = XW'(1);
    localparam logic [XW-1:0] XFER_HI  = XW'(2);
    localparam logic [XW-1:0] XFER_END = XW'(NUM_XFER);

    rd_state_e         state_q, state_d;
    logic              tick, hold, shift_en, byte_done;
    logic [BYTE_W-1:0] byte_val;
    logic [XW-1:0]     xfer_q;

    assign hold     = (state_q == S_IDLE) || (state_q == S_RELEASE);
    assign shift_en = (state_q == S_BIT_LO) && tick;

    adc_rd_halfper #(.HALF(HALF)) u_half (
        .clk  (clk),
        .rst  (rst),
        .hold (hold),
        .tick (tick)
    );

    adc_rd_shift #(.W(BYTE_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .clear     (state_q == S_IDLE),
        .shift_en  (shift_en),
        .bit_in    (adc_din),
        .byte_q    (byte_val),
        .byte_done (byte_done)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start) state_d = S_PRE_LOW;
            S_PRE_LOW: if (tick)  state_d = S_SELECT;
            S_SELECT:  if (tick)  state_d = S_XTRA_HI;
            S_XTRA_HI: if (tick)  state_d = S_XTRA_LO;
            S_XTRA_LO: if (tick)  state_d = S_ARM;
            S_ARM:     if (tick)  state_d = S_BIT_LO;
            S_BIT_LO:  if (tick)  state_d = S_BIT_HI;
            S_BIT_HI:  if (tick)  state_d = (xfer_q == XFER_END) ? S_RELEASE : S_BIT_LO;
            S_RELEASE: state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    always_comb begin
        adc_sel_n = 1'b0;
        adc_clk   = 1'b1;
        unique case (state_q)
            S_IDLE, S_RELEASE: adc_sel_n = 1'b1;
            S_PRE_LOW: begin
                adc_sel_n = 1'b1;
                adc_clk   = 1'b0;
            end
            S_SELECT, S_XTRA_LO, S_BIT_LO: adc_clk = 1'b0;
            default: adc_clk = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            xfer_q <= '0;
            res_hi <= '0;
            res_lo <= '0;
            done   <= 1'b0;
        end else begin
            done <= (state_q == S_RELEASE);
            if (state_q == S_IDLE) begin
                xfer_q <= '0;
            end else if (byte_done) begin
                xfer_q <= xfer_q + 1'b1;
                if (xfer_q == XFER_LO) res_lo <= byte_val & LO_MASK;
                if (xfer_q == XFER_HI) res_hi <= byte_val;
            end
        end
    end

    // R2: select only falls while the serial clock is parked low
    assert_clk_low_at_select_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_sel_n) |-> (!adc_clk && $past(!adc_clk)));

    // R8: done follows a cycle in which select was already high, and lasts one cycle
    assert_done_after_release_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (adc_sel_n && $past(adc_sel_n) && !$past(done)));

    // R9: once past the first state, nothing re-enters the parking state
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q != S_IDLE && state_q != S_PRE_LOW) |=> (state_q != S_PRE_LOW));
endmodule

// File: tb/adc_aligned_reader_bench.sv
module adc_aligned_reader_bench;
    localparam int CLK_DIV = 12;
    localparam int H = CLK_DIV / 2;
    localparam int L = 53 * H;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic adc_din = 1'b1;
    logic adc_sel_n, adc_clk, done;
    logic [7:0] res_hi, res_lo;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    int m = -1;
    int fall_k = 0;
    logic [11:0] adc_val = 12'h000;

    always #10 clk = ~clk;

    adc_aligned_reader #(.CLK_DIV(CLK_DIV)) u_adc_aligned_reader (
        .clk(clk), .rst(rst), .start(start), .adc_din(adc_din),
        .adc_sel_n(adc_sel_n), .adc_clk(adc_clk),
        .res_hi(res_hi), .res_lo(res_lo), .done(done)
    );

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural converter: null bit, word MSB first, then LSB first, then zeros
    function automatic logic conv_bit(input int k);
        if (k < 2) return 1'b1;
        if (k == 2) return 1'b0;
        if (k <= 14) return adc_val[14 - k];
        if (k <= 25) return adc_val[k - 14];
        return 1'b0;
    endfunction

    always @(negedge adc_sel_n) begin
        fall_k = 0;
        adc_din = 1'b1;
    end

    always @(negedge adc_clk) begin
        if (adc_sel_n === 1'b0) begin
            fall_k = fall_k + 1;
            adc_din = conv_bit(fall_k);
        end
    end

    // reference timeline: m counts cycles since an accepted start
    always @(posedge clk) begin
        cycles++;
        if (rst) m = -1;
        else if (m == -1 || m == L + 1) m = start ? 0 : -1;
        else m = m + 1;
    end

    always @(negedge clk) begin
        if (!rst) begin
            logic [2:0] exp_w;
            string tag;
            int s;
            if (m == -1) begin
                exp_w = 3'b110; tag = "R9 idle";
            end else if (m == L) begin
                exp_w = 3'b110; tag = "R8 release";
            end else if (m == L + 1) begin
                exp_w = 3'b111; tag = "R8 done";
            end else begin
                s = m / H;
                case (s)
                    0: begin exp_w = 3'b100; tag = "R2 park"; end
                    1: begin exp_w = 3'b000; tag = "R2 select"; end
                    2: begin exp_w = 3'b010; tag = "R3 extra hi"; end
                    3: begin exp_w = 3'b000; tag = "R3 extra lo"; end
                    4: begin exp_w = 3'b010; tag = "R3 arm"; end
                    default: begin
                        exp_w = ((s - 5) % 2 == 0) ? 3'b000 : 3'b010;
                        tag = "R4 bit";
                    end
                endcase
            end
            check({adc_sel_n, adc_clk, done} === exp_w, tag,
                  {13'd0, adc_sel_n, adc_clk, done}, {13'd0, exp_w});
        end
    end

    task automatic wait_done_and_check(input logic [11:0] v);
        while (done !== 1'b1) @(negedge clk);
        check(res_hi === v[11:4], "R5/R7 res_hi", {8'd0, res_hi}, {8'd0, v[11:4]});
        check(res_lo === {v[3:0], 4'h0}, "R6 res_lo", {8'd0, res_lo}, {8'd0, v[3:0], 4'h0});
    endtask

    task automatic do_read(input logic [11:0] v);
        @(negedge clk);
        adc_val = v;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done_and_check(v);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(adc_sel_n === 1'b1 && adc_clk === 1'b1 && done === 1'b0, "R1 lines",
              {13'd0, adc_sel_n, adc_clk, done}, 16'h0006);
        check(res_hi === 8'h00 && res_lo === 8'h00, "R1 results", {res_hi, res_lo}, 16'h0000);

        do_read(12'hA5C);
        do_read(12'h000);
        do_read(12'hFFF);
        do_read(12'h801);
        do_read(12'h3C6);

        // R9: start pulses in mid-read are ignored
        @(negedge clk);
        adc_val = 12'h6B9;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (100) @(negedge clk);
        start = 1'b1;
        repeat (3) @(negedge clk);
        start = 1'b0;
        wait_done_and_check(12'h6B9);
        repeat (20) @(negedge clk);

        // R9: start held through the done cycle starts a back-to-back read
        adc_val = 12'h1E7;
        start = 1'b1;
        wait_done_and_check(12'h1E7);
        @(negedge clk);
        start = 1'b0;
        wait_done_and_check(12'h1E7);
        repeat (10) @(negedge clk);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule